// File: doc/BRIEF.md
# Single-Wire Slave Bit Timing Engine

This block is the physical layer of a slave on a single open-drain data line that idles high. The line arrives asynchronously, passes through a two-flop synchronizer and is timed against a system clock. Every slot begins with a falling edge from the master. The block measures each low period. A long low period is a bus reset, which the block answers with a presence pulse. A short or medium low period is a data slot, which the block reports to the upper layer as one bit. When the upper layer asks for a zero in a read slot, the block pulls the line low for a fixed hold time.

Two timing sets are kept, one for standard speed and one for overdrive. The upper layer raises the speed flag. The length of a reset decides whether the flag is kept or cleared. After every rising edge there is a short hold-off window in which falling edges are ignored, so that ringing does not start a false slot. All durations are parameters counted in clock cycles. The effective low time is the number of cycles the synchronized line stays low.

Top module: `sw_slave_phy`

## Requirements
- R1: After reset, pull_low_o, od_o, bit_valid_o and bus_rst_o are all 0.
- R2: At standard speed, a low period of at least STD_RST_MIN cycles gives a one-cycle bus_rst_o pulse when the line returns high. A shorter low period (for example 800 cycles with the bench settings) gives no pulse.
- R3: After a bus reset, pull_low_o rises PDH+1 cycles after bus_rst_o and stays high for exactly PDL cycles. The PDH and PDL values used are those of the speed that is in effect after the reset.
- R4: Each slot gives exactly one one-cycle bit_valid_o. bit_o is 1 if the line rose before the speed's sample point (STD_SMP or OD_SMP cycles), and 0 if the line was still low at the sample point.
- R5: If tx_en_i=1 and tx_bit_i=0 when a slot starts, pull_low_o is high for exactly RDL cycles from the start of the slot, and the slot reads as 0. With tx_bit_i=1, or with tx_en_i=0, the block does not drive the line.
- R6: A pulse on od_set_i sets od_o to 1 from the next cycle, and the overdrive sample point then applies.
- R7: In overdrive, a low period from OD_RST_MIN up to OD_RST_MAX cycles is a bus reset, od_o stays 1, and the presence pulse uses overdrive timing.
- R8: A low period of at least STD_RST_MIN cycles always clears od_o to 0.
- R9: In overdrive, a low period longer than OD_RST_MAX and shorter than STD_RST_MIN is still a bus reset, clears od_o to 0, and is followed by a standard-speed presence pulse.
- R10: A falling edge less than HOLD cycles after a rising edge is ignored: it starts no slot and reports no bit. A falling edge after the window starts a new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw state of the data line |
| pull_low_o | output | 1 | Enables the open-drain pulldown |
| bit_valid_o | output | 1 | One-cycle strobe when a slot bit is decided |
| bit_o | output | 1 | Decoded slot bit |
| tx_en_i | input | 1 | The next slot is a read slot |
| tx_bit_i | input | 1 | Bit to return in the read slot |
| bus_rst_o | output | 1 | One-cycle strobe when a bus reset is recognized |
| od_set_i | input | 1 | Pulse that switches to overdrive timing |
| od_o | output | 1 | Current speed: 1 means overdrive |

## Verification
Checks made on every cycle: the reset and bit strobes each last one cycle, the speed flag is set after a request pulse, any reset that reaches the standard threshold leaves the block at standard speed, and a falling edge inside the hold-off window cannot leave the idle state. The other behaviours can only be shown by the bench's scenarios, because they depend on exact low-time thresholds. These are the choice between write-one and write-zero, the three reset-length outcomes in overdrive, the presence delay and width for each speed, the length of the read-zero drive, and the difference between a glitch inside the hold-off window and a proper slot just after it.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int CW = 20;
  typedef logic [CW-1:0] cyc_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_PWAIT, ST_PDRV} st_e;
  typedef struct packed {
    cyc_t rst_min;
    cyc_t smp;
    cyc_t pdh;
    cyc_t pdl;
    cyc_t rdl;
    cyc_t hold;
  } tim_t;
endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;  // line idles high
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/swp_tsel.sv
module swp_tsel
  import swp_pkg::*;
#(
  parameter int STD_RST_MIN = 4800,
  parameter int OD_RST_MIN  = 480,
  parameter int STD_SMP     = 300,
  parameter int OD_SMP      = 30,
  parameter int STD_PDH     = 300,
  parameter int OD_PDH      = 30,
  parameter int STD_PDL     = 1200,
  parameter int OD_PDL      = 120,
  parameter int STD_RDL     = 450,
  parameter int OD_RDL      = 50,
  parameter int STD_HOLD    = 50,
  parameter int OD_HOLD     = 10
) (
  input  logic od_i,
  output tim_t tim_o
);
  localparam tim_t TIM_STD = '{rst_min: cyc_t'(STD_RST_MIN), smp: cyc_t'(STD_SMP),
                               pdh: cyc_t'(STD_PDH), pdl: cyc_t'(STD_PDL),
                               rdl: cyc_t'(STD_RDL), hold: cyc_t'(STD_HOLD)};
  localparam tim_t TIM_OD  = '{rst_min: cyc_t'(OD_RST_MIN), smp: cyc_t'(OD_SMP),
                               pdh: cyc_t'(OD_PDH), pdl: cyc_t'(OD_PDL),
                               rdl: cyc_t'(OD_RDL), hold: cyc_t'(OD_HOLD)};

  assign tim_o = od_i ? TIM_OD : TIM_STD;
endmodule

// File: rtl/swp_holdoff.sv
module swp_holdoff
  import swp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  cyc_t hold_i,
  output logic busy_o
);
  cyc_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (rise_i)       cnt_q <= hold_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_HOLD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && hold_i > cyc_t'(1)) |=> busy_o);  // R10
endmodule

// File: rtl/sw_slave_phy.sv
module sw_slave_phy
  import swp_pkg::*;
#(
  parameter int STD_RST_MIN = 4800,
  parameter int OD_RST_MIN  = 480,
  parameter int OD_RST_MAX  = 800,
  parameter int STD_SMP     = 300,
  parameter int OD_SMP      = 30,
  parameter int STD_PDH     = 300,
  parameter int OD_PDH      = 30,
  parameter int STD_PDL     = 1200,
  parameter int OD_PDL      = 120,
  parameter int STD_RDL     = 450,
  parameter int OD_RDL      = 50,
  parameter int STD_HOLD    = 50,
  parameter int OD_HOLD     = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pull_low_o,
  output logic bit_valid_o,
  output logic bit_o,
  input  logic tx_en_i,
  input  logic tx_bit_i,
  output logic bus_rst_o,
  input  logic od_set_i,
  output logic od_o
);
  localparam cyc_t LONG_RST = cyc_t'(STD_RST_MIN);
  localparam cyc_t OD_KEEP  = cyc_t'(OD_RST_MAX);

  logic line_s, line_p, fall, rise;
  logic ho_busy;
  tim_t tim;
  st_e  state_q;
  cyc_t cnt_q;
  logic rd_zero_q, smp_done_q, od_q;
  logic rst_evt, low_long;

  swp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s));

  swp_tsel #(
    .STD_RST_MIN(STD_RST_MIN), .OD_RST_MIN(OD_RST_MIN),
    .STD_SMP(STD_SMP), .OD_SMP(OD_SMP), .STD_PDH(STD_PDH), .OD_PDH(OD_PDH),
    .STD_PDL(STD_PDL), .OD_PDL(OD_PDL), .STD_RDL(STD_RDL), .OD_RDL(OD_RDL),
    .STD_HOLD(STD_HOLD), .OD_HOLD(OD_HOLD)
  ) u_tsel (.od_i(od_q), .tim_o(tim));

  swp_holdoff u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .hold_i(tim.hold), .busy_o(ho_busy));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_p <= 1'b1;
    else         line_p <= line_s;
  end

  assign fall     = line_p & ~line_s;
  assign rise     = ~line_p & line_s;
  assign rst_evt  = (state_q == ST_LOW) && rise && (cnt_q >= tim.rst_min);
  assign low_long = (cnt_q >= LONG_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      rd_zero_q   <= 1'b0;
      smp_done_q  <= 1'b0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      bus_rst_o   <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      bus_rst_o   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall && !ho_busy) begin
            state_q    <= ST_LOW;
            cnt_q      <= '0;
            rd_zero_q  <= tx_en_i & ~tx_bit_i;
            smp_done_q <= 1'b0;
          end
        end
        ST_LOW: begin
          if (rise) begin
            rd_zero_q <= 1'b0;
            cnt_q     <= '0;
            if (rst_evt) begin
              bus_rst_o <= 1'b1;
              state_q   <= ST_PWAIT;
            end else begin
              state_q <= ST_IDLE;
              if (!smp_done_q) begin
                bit_valid_o <= 1'b1;
                bit_o       <= 1'b1;
              end
            end
          end else begin
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            if (!smp_done_q && cnt_q == tim.smp) begin
              bit_valid_o <= 1'b1;
              bit_o       <= 1'b0;
              smp_done_q  <= 1'b1;
            end
          end
        end
        ST_PWAIT: begin
          if (cnt_q == tim.pdh) begin
            state_q <= ST_PDRV;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PDRV: begin
          if (cnt_q >= tim.pdl - 1'b1) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // speed flag: reset length rule wins over a set request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       od_q <= 1'b0;
    else if (rst_evt)  od_q <= od_q && (cnt_q <= OD_KEEP);
    else if (od_set_i) od_q <= 1'b1;
  end

  assign od_o       = od_q;
  assign pull_low_o = (state_q == ST_PDRV) ||
                      ((state_q == ST_LOW) && rd_zero_q && (cnt_q < tim.rdl));

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |=> !bus_rst_o);  // R2
  AST_BIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);  // R4
  AST_OD_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_set_i && !rst_evt) |=> od_o);  // R6
  AST_LONG_RST_STD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_evt && low_long) |=> !od_o);  // R8
  AST_HOLDOFF_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && fall && ho_busy) |=> (state_q == ST_IDLE));  // R10
endmodule

// File: tb/sim_sw_slave_phy.sv
`timescale 1ns/1ps
module sim_sw_slave_phy;
  localparam int STD_RST_MIN = 1920, OD_RST_MIN = 192, OD_RST_MAX = 320;
  localparam int STD_SMP = 120, OD_SMP = 12, STD_PDH = 120, OD_PDH = 12;
  localparam int STD_PDL = 480, OD_PDL = 48, STD_RDL = 180, OD_RDL = 20;
  localparam int STD_HOLD = 20, OD_HOLD = 4;

  logic clk = 0, rst_ni = 0, m_line = 1;
  logic tx_en = 0, tx_bit = 0, od_set = 0;
  logic pull_low_o, bit_valid_o, bit_o, bus_rst_o, od_o;
  wire  line = m_line & ~pull_low_o;

  always #2.5 clk = ~clk;

  sw_slave_phy #(
    .STD_RST_MIN(STD_RST_MIN), .OD_RST_MIN(OD_RST_MIN), .OD_RST_MAX(OD_RST_MAX),
    .STD_SMP(STD_SMP), .OD_SMP(OD_SMP), .STD_PDH(STD_PDH), .OD_PDH(OD_PDH),
    .STD_PDL(STD_PDL), .OD_PDL(OD_PDL), .STD_RDL(STD_RDL), .OD_RDL(OD_RDL),
    .STD_HOLD(STD_HOLD), .OD_HOLD(OD_HOLD), .SYNC_STAGES(2)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line), .pull_low_o(pull_low_o),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o), .tx_en_i(tx_en), .tx_bit_i(tx_bit),
    .bus_rst_o(bus_rst_o), .od_set_i(od_set), .od_o(od_o));

  int cyc = 0, n_bits = 0, n_rst = 0, pd_cyc = 0, pd_rise = 0, t_rst = 0, t_pd = 0;
  logic last_bit = 0, pd_prev = 0;
  int total = 0, fails = 0;

  always @(negedge clk) begin
    cyc++;
    if (bit_valid_o) begin n_bits++; last_bit = bit_o; end
    if (bus_rst_o) begin n_rst++; t_rst = cyc; end
    if (pull_low_o) pd_cyc++;
    if (pull_low_o && !pd_prev) begin pd_rise++; t_pd = cyc; end
    pd_prev = pull_low_o;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_bits = 0; n_rst = 0; pd_cyc = 0; pd_rise = 0;
  endtask

  task automatic low(input int n, input int rec);
    m_line = 0; step(n); m_line = 1; step(rec);
  endtask

  task automatic t_reset_state();
    chk(pull_low_o == 0 && od_o == 0, "R1 drive/od", {pull_low_o, od_o}, 0);
    chk(bit_valid_o == 0 && bus_rst_o == 0, "R1 strobes", {bit_valid_o, bus_rst_o}, 0);
  endtask

  task automatic t_std_reset();
    clr(); low(2000, 1200);
    chk(n_rst == 1, "R2 reset pulse", n_rst, 1);
    chk(pd_rise == 1 && t_pd - t_rst == STD_PDH + 1, "R3 presence delay", t_pd - t_rst, STD_PDH + 1);
    chk(pd_cyc == STD_PDL, "R3 presence width", pd_cyc, STD_PDL);
    clr(); low(800, 600);
    chk(n_rst == 0, "R2 short low no reset", n_rst, 0);
  endtask

  task automatic wbit(input bit b, input int lo1, input int lo0, input int rec, input string req);
    clr(); low(b ? lo1 : lo0, rec);
    chk(n_bits == 1 && last_bit == b, req, {n_bits, 1'b0, last_bit}, {1, 1'b0, b});
  endtask

  task automatic t_std_writes();
    wbit(1, 8, 260, 300, "R4 std one");
    wbit(0, 8, 260, 300, "R4 std zero");
    wbit(1, 8, 260, 300, "R4 std one b");
    wbit(0, 8, 260, 300, "R4 std zero b");
  endtask

  task automatic rd(input bit en, input bit b, input int exp_pd, input bit exp_bit, input string req);
    tx_en = en; tx_bit = b; clr();
    low(4, 400);
    tx_en = 0;
    chk(pd_cyc == exp_pd, req, pd_cyc, exp_pd);
    chk(n_bits == 1 && last_bit == exp_bit, req, last_bit, exp_bit);
  endtask

  task automatic t_reads();
    rd(1, 0, STD_RDL, 0, "R5 read zero");
    rd(1, 1, 0, 1, "R5 read one");
    rd(0, 0, 0, 1, "R5 not enabled");
  endtask

  task automatic t_od_set();
    od_set = 1; step(1); od_set = 0; step(1);
    chk(od_o == 1, "R6 od set", od_o, 1);
    wbit(1, 4, 40, 60, "R6 od one");
    wbit(0, 4, 40, 60, "R6 od zero");
  endtask

  task automatic rst_slot(input int len, input bit exp_od, input int exp_pd, input string req);
    clr(); low(len, 1500);
    chk(n_rst == 1 && od_o == exp_od, req, {n_rst, 1'b0, od_o}, {1, 1'b0, exp_od});
    chk(pd_cyc == exp_pd, req, pd_cyc, exp_pd);
  endtask

  task automatic t_od_resets();
    rst_slot(240, 1, OD_PDL, "R7 od keep");
    rst_slot(800, 0, STD_PDL, "R9 mid reset");
    od_set = 1; step(1); od_set = 0; step(1);
    rst_slot(2000, 0, STD_PDL, "R8 long reset");
  endtask

  task automatic t_holdoff();
    clr();
    m_line = 0; step(4); m_line = 1; step(6); m_line = 0; step(4); m_line = 1; step(300);
    chk(n_bits == 1 && pd_cyc == 0, "R10 glitch ignored", n_bits, 1);
    clr();
    m_line = 0; step(4); m_line = 1; step(40); m_line = 0; step(4); m_line = 1; step(300);
    chk(n_bits == 2, "R10 after window", n_bits, 2);
  endtask

  initial begin
    step(5); rst_ni = 1; step(5);
    t_reset_state();
    t_std_reset();
    t_std_writes();
    t_reads();
    t_holdoff();
    t_od_set();
    t_od_resets();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule